// File: doc/BRIEF.md
# Privileged Instruction Trap Classifier

This block sits right after instruction decode. It is purely combinational. For each privileged or hypervisor-class instruction it decides whether the instruction may execute or must trap, and which exception cause the trap carries. Decode presents the instruction class as a one-hot strobe vector. The block also takes the current privilege level, the virtualization flag, a flag saying whether the hypervisor extension is present, and the trap-control status bits: wait timeout, virtual-memory trap, return trap, and the guest-level return and virtual-memory traps.

Every privilege violation falls into one of two kinds. An illegal-instruction trap has cause 2. A virtual-instruction trap has cause 22 (0x16). Which one applies depends on the virtualization mode and the hypervisor trap controls. When both kinds match, the illegal-instruction trap wins. The instructions' own side effects (halting, flushing, memory access) belong to downstream logic.

Top module: `pit_trap_classifier`

## Requirements
- R1: Class strobe bit positions are 0 return-from-supervisor, 1 wait-for-interrupt, 2 supervisor fence, 3 guest-virtual fence, 4 guest-physical fence, 5 hypervisor load, 6 hypervisor store, 7 hypervisor execute-load, 8 hypervisor CSR access. With no strobe set, execute=1, trap=0 and cause=0.
- R2: trap is always the inverse of execute. Privilege encodings are user=0, supervisor=1 and machine=3. A trap reports cause 2 (illegal) or 22 (virtual). When execute=1, cause is 0.
- R3: Return-from-supervisor (bit 0) is illegal at user privilege, and also at non-virtualized supervisor privilege with the return-trap bit set. Otherwise it is a virtual-instruction trap when the hypervisor extension is present, virtualization is on and the guest return-trap bit is set.
- R4: Wait-for-interrupt (bit 1) is a virtual-instruction trap when virtualization is on, or when the privilege is supervisor and the wait-timeout bit is set. In every other case it executes.
- R5: Supervisor fence (bit 2) is illegal at supervisor privilege with the virtual-memory trap bit set. Otherwise it is a virtual-instruction trap when the hypervisor extension is present, virtualization is on and the guest virtual-memory trap bit is set.
- R6: Guest-virtual fence (bit 3) executes in machine mode or in non-virtualized supervisor mode. It is a virtual-instruction trap in virtualized supervisor mode, and illegal at user privilege.
- R7: Guest-physical fence (bit 4) is illegal in non-virtualized supervisor mode with the virtual-memory trap bit set. In every other case it follows R6.
- R8: Hypervisor load, store and execute-load (bits 5 to 7) execute in machine mode or non-virtualized supervisor mode. Otherwise they are a virtual-instruction trap when virtualization is on, and illegal when it is off.
- R9: Hypervisor CSR access (bit 8) executes only in machine mode or non-virtualized supervisor mode. Every other case is a virtual-instruction trap.
- R10: When an illegal condition and a virtual condition both hold for one instruction, the cause is 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cls_i | input | 9 | One-hot instruction class strobes (bit map in R1) |
| priv_i | input | 2 | Current privilege level |
| virt_i | input | 1 | Virtualization active |
| hext_i | input | 1 | Hypervisor extension present |
| tw_i | input | 1 | Wait-timeout trap control |
| tvm_i | input | 1 | Virtual-memory trap control |
| tsr_i | input | 1 | Return trap control |
| vtsr_i | input | 1 | Guest return trap control |
| vtvm_i | input | 1 | Guest virtual-memory trap control |
| exec_o | output | 1 | Instruction may proceed |
| trap_o | output | 1 | Instruction traps |
| cause_o | output | 5 | Exception cause when trapping |

## Verification
The assertions assume that at most one class strobe is high, that the privilege is never the reserved value 2, and that virtualization is never on in machine mode. The random stimulus draws the privilege only from {0, 1, 3} and forces virtualization low whenever machine mode is drawn. It sets either a single strobe bit or none, while the status bits are drawn freely. The directed cases sweep the priority overlaps and the mode boundaries under the same constraints.

// File: rtl/pit_pkg.sv
package pit_pkg;

    localparam int NCLS    = 9;
    localparam int CAUSE_W = 5;

    typedef enum logic [1:0] {
        PRIV_U   = 2'd0,
        PRIV_S   = 2'd1,
        PRIV_RSV = 2'd2,
        PRIV_M   = 2'd3
    } priv_e;

    typedef enum int {
        CL_SRET  = 0,
        CL_WFI   = 1,
        CL_SFENCE= 2,
        CL_HFVV  = 3,
        CL_HFGV  = 4,
        CL_HLOAD = 5,
        CL_HSTORE= 6,
        CL_HLVX  = 7,
        CL_HCSR  = 8
    } cls_e;

    localparam logic [CAUSE_W-1:0] CAUSE_NONE = 5'd0;
    localparam logic [CAUSE_W-1:0] CAUSE_ILL  = 5'd2;
    localparam logic [CAUSE_W-1:0] CAUSE_VIRT = 5'h16;

    // decoded mode context shared by all rule evaluators
    typedef struct packed {
        logic lvl_u;    // user privilege, any virtualization
        logic lvl_s;    // supervisor privilege, any virtualization
        logic lvl_m;
        logic host_s;   // supervisor, not virtualized
        logic guest_s;  // supervisor, virtualized
        logic virt;
        logic hext;
        logic tw;
        logic tvm;
        logic tsr;
        logic vtsr;
        logic vtvm;
    } mode_ctx_t;

    typedef struct packed {
        logic ill;
        logic vi;
    } verdict_t;

    function automatic verdict_t rule_f(input int k, input mode_ctx_t c);
        verdict_t v;
        logic     host_ok;
        host_ok = c.lvl_m | c.host_s;
        v       = '0;
        case (k)
            CL_SRET: begin
                v.ill = c.lvl_u | (c.host_s & c.tsr);
                v.vi  = c.hext & c.virt & c.vtsr;
            end
            CL_WFI: begin
                v.vi  = c.virt | (c.lvl_s & c.tw);
            end
            CL_SFENCE: begin
                v.ill = c.lvl_s & c.tvm;
                v.vi  = c.hext & c.virt & c.vtvm;
            end
            CL_HFVV: begin
                v.vi  = c.guest_s;
                v.ill = ~host_ok & ~c.guest_s;
            end
            CL_HFGV: begin
                v.ill = (c.host_s & c.tvm) | (~host_ok & ~c.guest_s);
                v.vi  = c.guest_s;
            end
            CL_HLOAD, CL_HSTORE, CL_HLVX: begin
                v.vi  = ~host_ok & c.virt;
                v.ill = ~host_ok & ~c.virt;
            end
            CL_HCSR: begin
                v.vi  = ~host_ok;
            end
            default: v = '0;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/pit_mode_decode.sv
module pit_mode_decode
    import pit_pkg::*;
(
    input  logic [1:0] priv_i,
    input  logic       virt_i,
    input  logic       hext_i,
    input  logic       tw_i,
    input  logic       tvm_i,
    input  logic       tsr_i,
    input  logic       vtsr_i,
    input  logic       vtvm_i,
    output mode_ctx_t  ctx_o
);
    priv_e lvl;
    assign lvl = priv_e'(priv_i);

    always_comb begin
        ctx_o         = '0;
        ctx_o.lvl_u   = (lvl == PRIV_U);
        ctx_o.lvl_s   = (lvl == PRIV_S);
        ctx_o.lvl_m   = (lvl == PRIV_M);
        ctx_o.host_s  = (lvl == PRIV_S) & ~virt_i;
        ctx_o.guest_s = (lvl == PRIV_S) &  virt_i;
        ctx_o.virt    = virt_i;
        ctx_o.hext    = hext_i;
        ctx_o.tw      = tw_i;
        ctx_o.tvm     = tvm_i;
        ctx_o.tsr     = tsr_i;
        ctx_o.vtsr    = vtsr_i;
        ctx_o.vtvm    = vtvm_i;
    end

    always_comb begin
        p_priv_valid_r2: assert (priv_i != PRIV_RSV)
            else $error("reserved privilege level presented");
        p_no_virt_in_m_r2: assert (!(virt_i && priv_i == PRIV_M))
            else $error("virtualization flagged in machine mode");
    end
endmodule

// File: rtl/pit_rule_eval.sv
module pit_rule_eval
    import pit_pkg::*;
#(
    parameter int N = NCLS
) (
    input  mode_ctx_t    ctx_i,
    output logic [N-1:0] ill_o,
    output logic [N-1:0] vi_o
);
    for (genvar k = 0; k < N; k++) begin : g_rule
        verdict_t v;
        assign v        = rule_f(k, ctx_i);
        assign ill_o[k] = v.ill;
        assign vi_o[k]  = v.vi;
    end
endmodule

// File: rtl/pit_cause_sel.sv
module pit_cause_sel
    import pit_pkg::*;
#(
    parameter int N  = NCLS,
    parameter int CW = CAUSE_W
) (
    input  logic [N-1:0]  cls_i,
    input  logic [N-1:0]  ill_i,
    input  logic [N-1:0]  vi_i,
    output logic          exec_o,
    output logic          trap_o,
    output logic [CW-1:0] cause_o
);
    logic ill_any, vi_any;

    assign ill_any = |(cls_i & ill_i);
    assign vi_any  = |(cls_i & vi_i);

    always_comb begin
        trap_o  = ill_any | vi_any;
        exec_o  = ~(ill_any | vi_any);
        if (ill_any)     cause_o = CW'(CAUSE_ILL);
        else if (vi_any) cause_o = CW'(CAUSE_VIRT);
        else             cause_o = CW'(CAUSE_NONE);
    end

    always_comb begin
        p_ill_wins_r10: assert (!(ill_any && vi_any) || cause_o == CW'(CAUSE_ILL))
            else $error("virtual cause chosen over illegal");
        p_idle_r1: assert (cls_i != '0 || (exec_o && !trap_o))
            else $error("trap without a class strobe");
    end
endmodule

// File: rtl/pit_trap_classifier.sv
module pit_trap_classifier
    import pit_pkg::*;
(
    input  logic [8:0] cls_i,
    input  logic [1:0] priv_i,
    input  logic       virt_i,
    input  logic       hext_i,
    input  logic       tw_i,
    input  logic       tvm_i,
    input  logic       tsr_i,
    input  logic       vtsr_i,
    input  logic       vtvm_i,
    output logic       exec_o,
    output logic       trap_o,
    output logic [4:0] cause_o
);
    mode_ctx_t        ctx;
    logic [NCLS-1:0]  ill_vec;
    logic [NCLS-1:0]  vi_vec;

    pit_mode_decode u_dec (
        .priv_i (priv_i),
        .virt_i (virt_i),
        .hext_i (hext_i),
        .tw_i   (tw_i),
        .tvm_i  (tvm_i),
        .tsr_i  (tsr_i),
        .vtsr_i (vtsr_i),
        .vtvm_i (vtvm_i),
        .ctx_o  (ctx)
    );

    pit_rule_eval #(.N(NCLS)) u_rules (
        .ctx_i (ctx),
        .ill_o (ill_vec),
        .vi_o  (vi_vec)
    );

    pit_cause_sel #(.N(NCLS), .CW(CAUSE_W)) u_sel (
        .cls_i   (cls_i),
        .ill_i   (ill_vec),
        .vi_i    (vi_vec),
        .exec_o  (exec_o),
        .trap_o  (trap_o),
        .cause_o (cause_o)
    );

    always_comb begin
        p_onehot_cls_r1: assert ($onehot0(cls_i))
            else $error("more than one class strobe");
        p_exec_trap_r2: assert (exec_o != trap_o)
            else $error("execute and trap not complementary");
        p_cause_code_r2: assert (exec_o ? (cause_o == CAUSE_NONE)
                                        : (cause_o == CAUSE_ILL || cause_o == CAUSE_VIRT))
            else $error("cause code out of set");
        p_hcsr_guest_r9: assert (!(cls_i[CL_HCSR] && virt_i) || cause_o == CAUSE_VIRT)
            else $error("hypervisor CSR access from guest not virtual-trapped");
        p_hmem_user_r8: assert (!((|cls_i[CL_HLVX:CL_HLOAD]) && priv_i == PRIV_U && !virt_i)
                                || cause_o == CAUSE_ILL)
            else $error("hypervisor memory access from host user not illegal");
    end
endmodule

// File: tb/tb_pit_trap_classifier.sv
module tb_pit_trap_classifier;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [8:0] cls = '0;
    logic [1:0] priv = 2'd3;
    logic       virt = 0, hext = 0, tw = 0, tvm = 0, tsr = 0, vtsr = 0, vtvm = 0;
    logic       exec_o, trap_o;
    logic [4:0] cause_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    pit_trap_classifier dut (
        .cls_i(cls), .priv_i(priv), .virt_i(virt), .hext_i(hext),
        .tw_i(tw), .tvm_i(tvm), .tsr_i(tsr), .vtsr_i(vtsr), .vtvm_i(vtvm),
        .exec_o(exec_o), .trap_o(trap_o), .cause_o(cause_o)
    );

    // reference: 0 = execute, 2 = illegal, 22 = virtual
    function automatic int ref_cause(input logic [8:0] c, input logic [1:0] p,
                                     input logic v, input logic h, input logic w,
                                     input logic tv, input logic ts, input logic vts,
                                     input logic vtv);
        bit m, hs, vs, u;
        m  = (p == 2'd3);
        hs = (p == 2'd1) && !v;
        vs = (p == 2'd1) && v;
        u  = (p == 2'd0);
        if (c[0]) begin
            if (u || (hs && ts)) return 2;
            if (h && v && vts) return 22;
            return 0;
        end
        if (c[1]) return (v || (p == 2'd1 && w)) ? 22 : 0;
        if (c[2]) begin
            if (p == 2'd1 && tv) return 2;
            return (h && v && vtv) ? 22 : 0;
        end
        if (c[3] || c[4]) begin
            if (c[4] && hs && tv) return 2;
            if (m || hs) return 0;
            return vs ? 22 : 2;
        end
        if (c[5] || c[6] || c[7]) begin
            if (m || hs) return 0;
            return v ? 22 : 2;
        end
        if (c[8]) return (m || hs) ? 0 : 22;
        return 0;
    endfunction

    function automatic string req_of(input logic [8:0] c);
        if (c[0]) return "R3";
        if (c[1]) return "R4";
        if (c[2]) return "R5";
        if (c[3]) return "R6";
        if (c[4]) return "R7";
        if (c[5] || c[6] || c[7]) return "R8";
        if (c[8]) return "R9";
        return "R1";
    endfunction

    task automatic check(input string req);
        int exp_c;
        exp_c = ref_cause(cls, priv, virt, hext, tw, tvm, tsr, vtsr, vtvm);
        n_chk++;
        if (int'(cause_o) != exp_c || exec_o != (exp_c == 0) || trap_o != (exp_c != 0)) begin
            n_fail++;
            $display("FAIL %s cls=%b priv=%0d virt=%0b: got exec=%0b trap=%0b cause=%0d, expected exec=%0b trap=%0b cause=%0d",
                     req, cls, priv, virt, exec_o, trap_o, cause_o,
                     exp_c == 0, exp_c != 0, exp_c);
        end
    endtask

    task automatic apply(input logic [8:0] c, input logic [1:0] p, input logic v,
                         input logic [5:0] st, input string req);
        @(posedge clk);
        cls = c; priv = p; virt = v;
        {hext, tw, tvm, tsr, vtsr, vtvm} = st;
        @(negedge clk);
        check(req);
    endtask

    initial begin
        fork
            begin
                repeat (150000) @(posedge clk);
                if (!done) begin
                    n_fail++; n_chk++;
                    $display("FAIL watchdog: got timeout, expected completion");
                    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
                    $finish;
                end
            end
        join_none

        repeat (3) @(posedge clk);
        rst = 1'b0;
        // reset state / idle: no strobe
        @(negedge clk); check("R1");
        apply(9'b0, 2'd0, 1'b1, 6'b111111, "R1");
        apply(9'b0, 2'd1, 1'b0, 6'b111111, "R2");

        // directed corner cases
        apply(9'b1 << 0, 2'd0, 1'b0, 6'b000000, "R3");  // sret at user
        apply(9'b1 << 0, 2'd1, 1'b0, 6'b000100, "R3");  // host S, tsr
        apply(9'b1 << 0, 2'd1, 1'b1, 6'b100010, "R3");  // guest S, vtsr
        apply(9'b1 << 0, 2'd0, 1'b1, 6'b100010, "R10"); // VU, vtsr -> illegal
        apply(9'b1 << 1, 2'd0, 1'b1, 6'b000000, "R4");
        apply(9'b1 << 1, 2'd1, 1'b0, 6'b010000, "R4");
        apply(9'b1 << 1, 2'd0, 1'b0, 6'b010000, "R4");
        apply(9'b1 << 2, 2'd1, 1'b1, 6'b101001, "R10"); // tvm and vtvm
        apply(9'b1 << 2, 2'd1, 1'b1, 6'b100001, "R5");
        apply(9'b1 << 2, 2'd1, 1'b1, 6'b000001, "R5");  // no hext
        apply(9'b1 << 3, 2'd1, 1'b1, 6'b000000, "R6");
        apply(9'b1 << 3, 2'd0, 1'b0, 6'b000000, "R6");
        apply(9'b1 << 3, 2'd3, 1'b0, 6'b001000, "R6");
        apply(9'b1 << 4, 2'd1, 1'b0, 6'b001000, "R7");
        apply(9'b1 << 4, 2'd1, 1'b1, 6'b001000, "R7");
        apply(9'b1 << 5, 2'd0, 1'b1, 6'b000000, "R8");
        apply(9'b1 << 6, 2'd0, 1'b0, 6'b000000, "R8");
        apply(9'b1 << 7, 2'd1, 1'b0, 6'b000000, "R8");
        apply(9'b1 << 8, 2'd0, 1'b0, 6'b000000, "R9");
        apply(9'b1 << 8, 2'd1, 1'b1, 6'b000000, "R9");
        apply(9'b1 << 8, 2'd3, 1'b0, 6'b000000, "R9");

        // constrained random
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < 4000; i++) begin
            logic [8:0] c;
            logic [1:0] p;
            logic       v;
            int         pick;
            pick = $urandom_range(0, 9);
            c    = (pick == 9) ? 9'b0 : (9'b1 << pick);
            case ($urandom_range(0, 2))
                0:       p = 2'd0;
                1:       p = 2'd1;
                default: p = 2'd3;
            endcase
            v = (p == 2'd3) ? 1'b0 : 1'($urandom_range(0, 1));
            apply(c, p, v, 6'($urandom_range(0, 63)), req_of(c));
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule